// File: doc/BRIEF.md
# Activity-Based Memory Temperature Estimator

This block tracks an estimated temperature for the memory modules without a sensor. It uses a first-order recursive filter that is driven by memory activity energy. An upstream counter supplies a running energy sample together with a valid strobe. On each strobed cycle the block takes the difference from the previously accepted sample. It then forms a new estimate: the old estimate multiplied by a decay factor, plus the energy difference multiplied by an energy-to-temperature gain. One estimator instance serves every module on every channel, so a single setting governs the whole memory system.

Both coefficients sit in one 32-bit configuration word. A host writes this word and reads it back through a plain write-enable/data port. The decay field resets to its largest value, which is just below unity. The gain resets to zero. The estimate resets to an ambient temperature that is presented on an input, and it is driven out as unsigned fixed point in degrees Celsius.

Top module: `mtemp_estimator`

## Requirements
- R1: While `rst` is high at a rising edge, the next `temp_out` equals `ambient`, and `cfg_rd_data` equals 0x000003FF (decay 0x3FF, gain 0).
- R2: A write (`cfg_wr_en` high) captures `cfg_wr_data[9:0]` as the decay factor and `cfg_wr_data[19:10]` as the gain. `cfg_rd_data` shows them in the same positions from the next cycle on. Bits 31:20 always read as zero, and writing them has no effect.
- R3: On a cycle with `e_valid` high, the next `temp_out` is floor((decay·T·1 + gain·Δ·256) / 1024). Here T is the current `temp_out` (8 integer bits, 8 fraction bits), decay and gain are fractions of 1024, and Δ is the energy difference in counter units.
- R4: When `e_valid` is low, `temp_out` holds its value and the sample on `e_sample` is not recorded as the previous sample.
- R5: Δ is (`e_sample` − previous accepted sample) modulo 2^16, so a counter wrap gives a small positive difference. The previous sample is 0 after reset.
- R6: When the R3 result exceeds 0xFFFF, `temp_out` becomes 0xFFFF instead of wrapping.
- R7: An update in the same cycle as a configuration write uses the coefficients held before that write. The new coefficients apply from the next update.
- R8: With both coefficients zero, an update drives `temp_out` to 0 whatever the energy difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_data | output | 32 | Configuration word readback |
| ambient | input | 16 | Reset value of the estimate, unsigned 8.8 degrees Celsius |
| e_valid | input | 1 | Energy sample valid; triggers one filter update |
| e_sample | input | 16 | Running activity-energy counter value |
| temp_out | output | 16 | Current estimate, unsigned 8.8 degrees Celsius |

## Verification
The bench targets the following corner cases:
- An energy counter that wraps from near 0xFFFF to a small value. A design that subtracts without modular arithmetic would produce a huge difference and saturate.
- Samples presented while the strobe is low. A design that latches them would compute the wrong difference on the next real update.
- Products that overflow the 16-bit estimate. A design without saturation would wrap to a small value.
- A configuration write that coincides with an update, which exposes any design that takes the new coefficients early.
- Truncation order: rounding each product separately instead of once gives results that differ by one LSB.

Long randomized runs compare every cycle against a behavioural integer model.

// File: rtl/mtemp_pkg.sv
package mtemp_pkg;

    // Configuration word layout (field positions are host-visible).
    localparam int CFG_W     = 32;
    localparam int COEF_W    = 10;
    localparam int COEF_FRAC = 10;
    localparam int DECAY_LSB = 0;
    localparam int GAIN_LSB  = DECAY_LSB + COEF_W;
    localparam int USED_TOP  = GAIN_LSB + COEF_W;

    localparam logic [COEF_W-1:0] DECAY_RST = '1;
    localparam logic [COEF_W-1:0] GAIN_RST  = '0;

    typedef logic [COEF_W-1:0] coef_t;

    typedef struct packed {
        coef_t gain;
        coef_t decay;
    } coef_pair_t;

    localparam coef_pair_t COEF_RST = '{gain: GAIN_RST, decay: DECAY_RST};

    function automatic coef_pair_t cfg_unpack(input logic [CFG_W-1:0] w);
        coef_pair_t c;
        c.decay = w[DECAY_LSB +: COEF_W];
        c.gain  = w[GAIN_LSB  +: COEF_W];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_pack(input coef_pair_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[DECAY_LSB +: COEF_W] = c.decay;
        w[GAIN_LSB  +: COEF_W] = c.gain;
        return w;
    endfunction

endpackage

// File: rtl/mtemp_cfg_reg.sv
module mtemp_cfg_reg
    import mtemp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output coef_pair_t       coef
);

    coef_pair_t coef_q;
    logic       unused_rsvd;

    // Reserved bits are discarded on write.
    assign unused_rsvd = ^wr_data[CFG_W-1:USED_TOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            coef_q <= COEF_RST;
        end else if (wr_en) begin
            coef_q <= cfg_unpack(wr_data);
        end
    end

    assign coef    = coef_q;
    assign rd_data = cfg_pack(coef_q);

endmodule

// File: rtl/mtemp_delta.sv
module mtemp_delta #(
    parameter int E_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           valid,
    input  logic [E_W-1:0] sample,
    output logic [E_W-1:0] delta
);

    logic [E_W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else if (valid) begin
            prev_q <= sample;
        end
    end

    // Modular difference: a wrapping counter yields a small positive delta.
    assign delta = sample - prev_q;

endmodule

// File: rtl/mtemp_filter.sv
module mtemp_filter
    import mtemp_pkg::*;
#(
    parameter int T_W    = 16,
    parameter int T_FRAC = 8,
    parameter int E_W    = 16,
    parameter int OUT_W  = 25
) (
    input  coef_pair_t       coef,
    input  logic [T_W-1:0]   temp,
    input  logic [E_W-1:0]   delta,
    output logic [OUT_W-1:0] sum_q
);

    localparam int A_W   = COEF_W + T_W;
    localparam int B_W   = COEF_W + E_W + T_FRAC;
    localparam int SUM_W = ((A_W > B_W) ? A_W : B_W) + 1;

    logic [SUM_W-1:0] decay_term;
    logic [SUM_W-1:0] gain_term;
    logic [SUM_W-1:0] total;
    logic             unused_lsbs;

    always_comb begin
        decay_term = SUM_W'(coef.decay) * SUM_W'(temp);
        gain_term  = (SUM_W'(coef.gain) * SUM_W'(delta)) << T_FRAC;
        total      = decay_term + gain_term;
    end

    // Single floor at the end, aligning to the estimate's fraction.
    assign sum_q       = OUT_W'(total >> COEF_FRAC);
    assign unused_lsbs = ^total[COEF_FRAC-1:0];

endmodule

// File: rtl/mtemp_state.sv
module mtemp_state #(
    parameter int T_W   = 16,
    parameter int OUT_W = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [T_W-1:0]   ambient,
    input  logic [OUT_W-1:0] sum_q,
    output logic [T_W-1:0]   temp
);

    localparam logic [T_W-1:0] T_MAX = '1;

    logic           ovf;
    logic [T_W-1:0] next_t;
    logic [T_W-1:0] temp_q;

    generate
        if (OUT_W > T_W) begin : g_sat
            assign ovf = |sum_q[OUT_W-1:T_W];
        end else begin : g_nosat
            assign ovf = 1'b0;
        end
    endgenerate

    assign next_t = ovf ? T_MAX : sum_q[T_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= ambient;
        end else if (upd) begin
            temp_q <= next_t;
        end
    end

    assign temp = temp_q;

endmodule

// File: rtl/mtemp_estimator.sv
module mtemp_estimator
    import mtemp_pkg::*;
#(
    parameter int E_W    = 16,
    parameter int T_INT  = 8,
    parameter int T_FRAC = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr_en,
    input  logic [CFG_W-1:0]        cfg_wr_data,
    output logic [CFG_W-1:0]        cfg_rd_data,
    input  logic [T_INT+T_FRAC-1:0] ambient,
    input  logic                    e_valid,
    input  logic [E_W-1:0]          e_sample,
    output logic [T_INT+T_FRAC-1:0] temp_out
);

    localparam int T_W   = T_INT + T_FRAC;
    localparam int A_W   = COEF_W + T_W;
    localparam int B_W   = COEF_W + E_W + T_FRAC;
    localparam int OUT_W = ((A_W > B_W) ? A_W : B_W) + 1 - COEF_FRAC;

    coef_pair_t       coef;
    logic [E_W-1:0]   delta;
    logic [OUT_W-1:0] sum_q;

    mtemp_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .coef    (coef)
    );

    mtemp_delta #(.E_W(E_W)) u_delta (
        .clk    (clk),
        .rst    (rst),
        .valid  (e_valid),
        .sample (e_sample),
        .delta  (delta)
    );

    mtemp_filter #(
        .T_W    (T_W),
        .T_FRAC (T_FRAC),
        .E_W    (E_W),
        .OUT_W  (OUT_W)
    ) u_filter (
        .coef  (coef),
        .temp  (temp_out),
        .delta (delta),
        .sum_q (sum_q)
    );

    mtemp_state #(.T_W(T_W), .OUT_W(OUT_W)) u_state (
        .clk     (clk),
        .rst     (rst),
        .upd     (e_valid),
        .ambient (ambient),
        .sum_q   (sum_q),
        .temp    (temp_out)
    );

endmodule

// File: rtl/mtemp_checker.sv
module mtemp_checker
    import mtemp_pkg::*;
#(
    parameter int T_W   = 16,
    parameter int OUT_W = 25
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr_en,
    input logic [CFG_W-1:0] cfg_wr_data,
    input logic [CFG_W-1:0] cfg_rd_data,
    input logic [T_W-1:0]   ambient,
    input logic             e_valid,
    input logic [T_W-1:0]   temp_out,
    input logic [OUT_W-1:0] sum_q
);

    localparam logic [T_W-1:0]   T_MAX   = '1;
    localparam logic [OUT_W-1:0] SUM_MAX = OUT_W'(T_MAX);

    logic unused_rsvd;
    assign unused_rsvd = ^cfg_wr_data[CFG_W-1:USED_TOP];

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (temp_out == $past(ambient)) && (cfg_rd_data == CFG_W'(DECAY_RST)));

    a_r2_write_capture: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |=> cfg_rd_data == CFG_W'($past(cfg_wr_data[USED_TOP-1:0])));

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !e_valid |=> $stable(temp_out));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (e_valid && (sum_q > SUM_MAX)) |=> temp_out == T_MAX);

endmodule

bind mtemp_estimator mtemp_checker #(.T_W(T_W), .OUT_W(OUT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .ambient     (ambient),
    .e_valid     (e_valid),
    .temp_out    (temp_out),
    .sum_q       (sum_q)
);

// File: tb/sim_mtemp_estimator.sv
module sim_mtemp_estimator;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic [15:0] ambient = 16'h1900;
    logic        e_valid = 1'b0;
    logic [15:0] e_sample = '0;
    logic [15:0] temp_out;

    int vectors = 0;
    int misses = 0;
    bit done = 0;

    // Behavioural model state
    longint m_temp, m_prev, m_decay, m_gain;

    always #(CLK_P/2) clk = ~clk;

    mtemp_estimator u0 (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .ambient(ambient), .e_valid(e_valid),
        .e_sample(e_sample), .temp_out(temp_out)
    );

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    // One clock: drive inputs at negedge, advance model, compare at next negedge.
    task automatic cyc(input bit r, input bit wr, input logic [31:0] wd,
                       input bit v, input logic [15:0] s, input string tag);
        longint n_temp, n_prev, n_decay, n_gain, d, full, q, exp_rd;
        rst = r; cfg_wr_en = wr; cfg_wr_data = wd; e_valid = v; e_sample = s;
        n_temp = m_temp; n_prev = m_prev; n_decay = m_decay; n_gain = m_gain;
        if (r) begin
            n_temp = longint'(ambient); n_prev = 0; n_decay = 1023; n_gain = 0;
        end else begin
            if (v) begin
                d = (longint'(s) - m_prev) & 64'hFFFF;
                full = m_decay * m_temp + m_gain * d * 256;
                q = full >> 10;
                if (q > 65535) q = 65535;
                n_temp = q;
                n_prev = longint'(s);
            end
            if (wr) begin
                n_decay = longint'(wd[9:0]);
                n_gain  = longint'(wd[19:10]);
            end
        end
        @(negedge clk);
        m_temp = n_temp; m_prev = n_prev; m_decay = n_decay; m_gain = n_gain;
        exp_rd = (m_gain << 10) | m_decay;
        vectors++;
        if (longint'(temp_out) != m_temp) begin
            misses++;
            $display("FAIL %s temp_out actual=%h expected=%h", tag, temp_out, m_temp[15:0]);
        end
        if (longint'(cfg_rd_data) != exp_rd) begin
            misses++;
            $display("FAIL %s cfg_rd_data actual=%h expected=%h", tag, cfg_rd_data, exp_rd[31:0]);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        m_temp = 0; m_prev = 0; m_decay = 0; m_gain = 0;
        @(negedge clk);
        // R1: reset state, with a write attempted during reset
        cyc(1, 0, 32'h0, 0, 16'h0, "R1");
        cyc(1, 1, 32'h000F_FFFF, 1, 16'h1234, "R1");
        // R4: samples offered without the strobe must not move anything
        cyc(0, 0, 32'h0, 0, 16'h0777, "R4");
        cyc(0, 0, 32'h0, 0, 16'hBEEF, "R4");
        // R2: reserved bits dropped, fields captured
        cyc(0, 1, 32'hABC5_5A3F, 0, 16'h0, "R2");
        cyc(0, 1, 32'hFFF0_0000, 0, 16'h0, "R2");
        // R8: zero coefficients clear the estimate on update
        cyc(0, 0, 32'h0, 1, 16'h0400, "R8");
        // R3/R5: first delta relative to zero after reset (R4 kept prev at 0)
        cyc(1, 0, 32'h0, 0, 16'h0, "R1");
        cyc(0, 1, {12'h0, 10'h200, 10'h3F0}, 0, 16'h0, "R2");
        cyc(0, 0, 32'h0, 1, 16'h0040, "R5");
        cyc(0, 0, 32'h0, 1, 16'h0100, "R3");
        cyc(0, 0, 32'h0, 1, 16'h0100, "R3");
        cyc(0, 0, 32'h0, 1, 16'h0133, "R3");
        cyc(0, 0, 32'h0, 0, 16'h9999, "R4");
        // R5: counter wrap
        cyc(0, 0, 32'h0, 1, 16'hFFF0, "R5");
        cyc(0, 0, 32'h0, 1, 16'h0010, "R5");
        // R7: write coinciding with update uses old coefficients
        cyc(0, 1, {12'h0, 10'h3FF, 10'h000}, 1, 16'h0030, "R7");
        cyc(0, 0, 32'h0, 1, 16'h0050, "R7");
        // R6: saturation and staying saturated
        cyc(0, 1, {12'h0, 10'h3FF, 10'h3FF}, 0, 16'h0050, "R2");
        cyc(0, 0, 32'h0, 1, 16'h8050, "R6");
        cyc(0, 0, 32'h0, 1, 16'hF000, "R6");
        cyc(0, 0, 32'h0, 1, 16'hF001, "R6");
        // Randomized sweep against the model
        for (int i = 0; i < 3000; i++) begin
            bit w, v;
            logic [31:0] wd;
            w  = ($urandom % 16) == 0;
            v  = ($urandom % 4) != 0;
            wd = $urandom;
            cyc(0, w, wd, v, 16'($urandom), "R3");
        end
        done = 1;
        report();
        $finish;
    end

endmodule